// File: doc/BRIEF.md
# Shared Victim Cache Tag Controller

This block controls the tags and per-line state of a last-level cache that four cores share. Lines enter it only when a core's private cache evicts them. No fill from memory ever allocates here. A core also looks the cache up when its private cache misses. It says whether the lookup is an instruction fetch or a data load, and the controller answers with hit or miss, the way, and whether the line stays resident after it moves to the requester.

Each request carries a line address. The low address bits select the set and the rest form the tag. The controller takes at most one request per clock from the four cores, chosen round-robin. It looks the request up in a set-associative tag array and, two clocks after the grant, returns one response tagged with the core number.

Each line keeps a 4-bit record of which cores have touched it, and this record decides what happens on a lookup hit. An instruction fetch always leaves the line resident. A data load leaves it resident only if two or more cores are already recorded. Otherwise the line is invalidated, because it now lives in the requester's private cache. Replacement follows one recently-used bit per way.

Top module: `victim_llc_top`

## Requirements
- R1: After reset there is no response and no grant, and every line is invalid, so the first lookup to any address misses.
- R2: At most one core is granted per cycle, and only a core that is requesting. The search begins at the core after the one last granted, wrapping from 3 to 0. After reset core 0 has first priority.
- R3: Each granted request produces exactly one response two clock edges after its grant cycle. `respCore` carries the granted core's number, and responses come out in grant order.
- R4: A victim (kind 0) whose tag is absent from the set allocates the lowest-numbered invalid way. The line's core record becomes the sender only. The response shows hit 0, kept 1 and the allocated way.
- R5: A victim whose tag is already resident in the set updates that same way in place and adds the sender to the core record. No second way is allocated. The response shows hit 1, kept 1 and that way.
- R6: An instruction-fetch lookup (kind 1) that hits keeps the line and adds the requester to its core record. The response shows hit 1, kept 1 and the way.
- R7: A data-load lookup (kind 2) that hits keeps the line, and adds the requester, only when the core record held two or more cores before the access. Otherwise the line is invalidated and its record is cleared. The response shows hit 1 and kept 1 or 0 to match.
- R8: A lookup that misses responds with hit 0, kept 0 and way 0, and changes no line.
- R9: Each way of a set has a recently-used bit. The bit is set when that way is allocated or hits and stays resident. If setting it would make every bit of the set 1, all other bits of the set are cleared. An invalidated way's bit is cleared. When a set has no invalid way, a victim miss replaces the lowest-numbered way whose bit is 0.
- R10: Request kind 3 behaves exactly as a data load (kind 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 4 | Per-core request pending, held until granted |
| reqKind | input | 8 | Per-core 2-bit kind, core c at bits 2c+1:2c (0 victim, 1 instruction fetch, 2 and 3 data load) |
| reqAddr | input | 64 | Per-core 16-bit line address, core c at bits 16c+15:16c; bits 3:0 select the set |
| reqGrant | output | 4 | One-hot grant this cycle, combinational from reqValid |
| respValid | output | 1 | Response strobe |
| respCore | output | 2 | Core the response belongs to |
| respHit | output | 1 | Tag was resident |
| respKept | output | 1 | Line is resident after the access |
| respWay | output | 5 | Way hit or allocated, 0 on a lookup miss |

## Verification
The bench targets these corner cases:
- A line whose record holds one core and then takes a data load. It must be dropped. A design that kept it would keep hitting on later fetches.
- A victim arriving twice from different cores. If it allocated a second way, the duplicate tags would show up as a wrong way or a double hit.
- Sets driven past 32 distinct tags, so that replacement must follow the recently-used bits and the wrap-around clear. An off-by-one in victim selection returns the wrong way number.
- All four cores requesting at once, and requests held across several cycles. A pointer that fails to advance starves a core, and a wrong latency shifts every response.

// File: rtl/victim_llc_pkg.sv
package victim_llc_pkg;

  // Request kind encoding on reqKind
  typedef enum logic [1:0] {
    KIND_VICTIM = 2'd0,
    KIND_IFETCH = 2'd1,
    KIND_DLOAD  = 2'd2,
    KIND_DLOAD3 = 2'd3
  } reqKind_e;

  // Line update strobes issued by control to the tag/state datapath
  typedef struct packed {
    logic alloc;  // write a new line into the chosen replacement way
    logic merge;  // OR the requester into the hit line's core record
    logic drop;   // invalidate the hit line
    logic touch;  // mark the target way recently used
  } lineStrb_t;

endpackage

// File: rtl/victim_llc_datapath.sv
module victim_llc_datapath
  import victim_llc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_SETS  = 16,
  parameter int NUM_WAYS  = 32,
  parameter int TAG_W     = 12,
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [SET_W-1:0]  lkSet,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic [CORE_W-1:0] lkCore,
  input  lineStrb_t         strb,
  output logic              dpHit,
  output logic [WAY_W-1:0]  dpHitWay,
  output logic [WAY_W-1:0]  dpAllocWay,
  output logic              dpShared
);

  logic [NUM_WAYS-1:0]  validArr [NUM_SETS];
  logic [NUM_WAYS-1:0]  mruArr   [NUM_SETS];
  logic [TAG_W-1:0]     tagArr   [NUM_SETS][NUM_WAYS];
  logic [NUM_CORES-1:0] shArr    [NUM_SETS][NUM_WAYS];

  logic [NUM_WAYS-1:0] hitVec;
  logic [NUM_WAYS-1:0] setValid;
  logic [NUM_WAYS-1:0] setMru;
  logic [WAY_W-1:0]    invWay, freeWay, tgtWay;
  logic [NUM_WAYS-1:0] wayBit, touchedMru;
  logic [NUM_CORES-1:0] coreBit;

  assign setValid = validArr[lkSet];
  assign setMru   = mruArr[lkSet];
  assign coreBit  = NUM_CORES'(1) << lkCore;

  // Tag compare across the set
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hitVec[w] = setValid[w] && (tagArr[lkSet][w] == lkTag);
  end

  // Lowest-index encoders: hit way, first invalid way, first not-recent way
  always_comb begin
    dpHitWay = '0;
    invWay   = '0;
    freeWay  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w])    dpHitWay = WAY_W'(w);
      if (!setValid[w]) invWay   = WAY_W'(w);
      if (!setMru[w])   freeWay  = WAY_W'(w);
    end
  end

  assign dpHit      = |hitVec;
  assign dpAllocWay = (&setValid) ? freeWay : invWay;
  assign dpShared   = $countones(shArr[lkSet][dpHitWay]) >= 2;
  assign tgtWay     = dpHit ? dpHitWay : dpAllocWay;
  assign wayBit     = NUM_WAYS'(1) << tgtWay;

  always_comb begin
    touchedMru = setMru | wayBit;
    if (&touchedMru) touchedMru = wayBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validArr[s] <= '0;
        mruArr[s]   <= '0;
      end
    end else if (lkValid) begin
      if (strb.alloc) validArr[lkSet][tgtWay] <= 1'b1;
      if (strb.drop) begin
        validArr[lkSet][tgtWay] <= 1'b0;
        mruArr[lkSet]           <= setMru & ~wayBit;
      end else if (strb.touch) begin
        mruArr[lkSet] <= touchedMru;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lkValid && strb.alloc) begin
      tagArr[lkSet][tgtWay] <= lkTag;
      shArr[lkSet][tgtWay]  <= coreBit;
    end else if (lkValid && strb.merge) begin
      shArr[lkSet][tgtWay] <= shArr[lkSet][tgtWay] | coreBit;
    end else if (lkValid && strb.drop) begin
      shArr[lkSet][tgtWay] <= '0;
    end
  end

  // A tag is never resident twice in one set (in-place victim update)
  p_single_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> $onehot0(hitVec));

  // Allocation is only requested when the tag is absent
  p_alloc_on_miss_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && strb.alloc) |-> !dpHit);

  // A drop only ever hits a line recorded by fewer than two cores
  p_drop_unshared_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && strb.drop) |-> (dpHit && $countones(shArr[lkSet][dpHitWay]) < 2));

  // A dropped line no longer matches on the following cycle
  p_drop_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && strb.drop) |=> !validArr[$past(lkSet)][$past(dpHitWay)]);

endmodule

// File: rtl/victim_llc_ctrl.sv
module victim_llc_ctrl
  import victim_llc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 16,
  parameter int NUM_WAYS  = 32,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int WAY_W  = $clog2(NUM_WAYS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [2*NUM_CORES-1:0]      reqKind,
  input  logic [ADDR_W*NUM_CORES-1:0] reqAddr,
  output logic [NUM_CORES-1:0]        reqGrant,
  output logic                        stValid,
  output logic [ADDR_W-1:0]           stAddr,
  output logic [CORE_W-1:0]           stCore,
  output lineStrb_t                   strb,
  input  logic                        dpHit,
  input  logic [WAY_W-1:0]            dpHitWay,
  input  logic [WAY_W-1:0]            dpAllocWay,
  input  logic                        dpShared,
  output logic                        respValid,
  output logic [CORE_W-1:0]           respCore,
  output logic                        respHit,
  output logic                        respKept,
  output logic [WAY_W-1:0]            respWay
);

  logic [CORE_W-1:0] lastGrant, grantIdx;
  logic              anyGrant;
  logic [1:0]        stKind;
  logic              isVictim, isIfetch, keptNext;

  // Round-robin search starting after the last granted core
  always_comb begin
    int cand;
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int i = 1; i <= NUM_CORES; i++) begin
      cand = (int'(lastGrant) + i) % NUM_CORES;
      if (!anyGrant && reqValid[cand]) begin
        anyGrant = 1'b1;
        grantIdx = CORE_W'(cand);
      end
    end
  end

  assign reqGrant = anyGrant ? (NUM_CORES'(1) << grantIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid   <= 1'b0;
      lastGrant <= CORE_W'(NUM_CORES - 1);
      stCore    <= '0;
      stKind    <= '0;
      stAddr    <= '0;
    end else begin
      stValid <= anyGrant;
      if (anyGrant) begin
        lastGrant <= grantIdx;
        stCore    <= grantIdx;
        stKind    <= reqKind[int'(grantIdx)*2 +: 2];
        stAddr    <= reqAddr[int'(grantIdx)*ADDR_W +: ADDR_W];
      end
    end
  end

  assign isVictim = (stKind == KIND_VICTIM);
  assign isIfetch = (stKind == KIND_IFETCH);
  assign keptNext = isVictim || (dpHit && (isIfetch || dpShared));

  // Keep-or-drop policy expressed as line strobes
  always_comb begin
    strb = '0;
    if (stValid) begin
      if (isVictim) begin
        strb.alloc = !dpHit;
        strb.merge = dpHit;
        strb.touch = 1'b1;
      end else if (dpHit) begin
        if (keptNext) begin
          strb.merge = 1'b1;
          strb.touch = 1'b1;
        end else begin
          strb.drop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCore  <= '0;
      respHit   <= 1'b0;
      respKept  <= 1'b0;
      respWay   <= '0;
    end else begin
      respValid <= stValid;
      respCore  <= stCore;
      respHit   <= stValid && dpHit;
      respKept  <= stValid && keptNext;
      respWay   <= dpHit ? dpHitWay : (isVictim ? dpAllocWay : '0);
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant));

  p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  p_resp_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|reqGrant) |=> ##1 respValid);

  p_miss_not_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit && respKept) |-> $past(isVictim));

endmodule

// File: rtl/victim_llc_top.sv
module victim_llc_top
  import victim_llc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_SETS  = 16,
  parameter int NUM_WAYS  = 32,
  parameter int ADDR_W    = 16,
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int TAG_W  = ADDR_W - SET_W,
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        reqValid,
  input  logic [2*NUM_CORES-1:0]      reqKind,
  input  logic [ADDR_W*NUM_CORES-1:0] reqAddr,
  output logic [NUM_CORES-1:0]        reqGrant,
  output logic                        respValid,
  output logic [CORE_W-1:0]           respCore,
  output logic                        respHit,
  output logic                        respKept,
  output logic [WAY_W-1:0]            respWay
);

  logic              stValid;
  logic [ADDR_W-1:0] stAddr;
  logic [CORE_W-1:0] stCore;
  lineStrb_t         strb;
  logic              dpHit, dpShared;
  logic [WAY_W-1:0]  dpHitWay, dpAllocWay;

  victim_llc_ctrl #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr), .reqGrant(reqGrant),
    .stValid(stValid), .stAddr(stAddr), .stCore(stCore), .strb(strb),
    .dpHit(dpHit), .dpHitWay(dpHitWay), .dpAllocWay(dpAllocWay), .dpShared(dpShared),
    .respValid(respValid), .respCore(respCore), .respHit(respHit),
    .respKept(respKept), .respWay(respWay)
  );

  victim_llc_datapath #(
    .NUM_CORES(NUM_CORES), .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .lkValid(stValid), .lkSet(stAddr[SET_W-1:0]), .lkTag(stAddr[ADDR_W-1:SET_W]),
    .lkCore(stCore), .strb(strb),
    .dpHit(dpHit), .dpHitWay(dpHitWay), .dpAllocWay(dpAllocWay), .dpShared(dpShared)
  );

endmodule

// File: tb/victim_llc_top_tb.sv
module victim_llc_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  reqValid = '0;
  logic [7:0]  reqKind = '0;
  logic [63:0] reqAddr = '0;
  logic [3:0]  reqGrant;
  logic        respValid, respHit, respKept;
  logic [1:0]  respCore;
  logic [4:0]  respWay;

  victim_llc_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqGrant(reqGrant), .respValid(respValid), .respCore(respCore),
    .respHit(respHit), .respKept(respKept), .respWay(respWay)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // Pending requests per core
  bit        pend  [4];
  logic [1:0]  pKind [4];
  logic [15:0] pAddr [4];

  // Reference state
  bit          mV   [16][32];
  logic [11:0] mT   [16][32];
  logic [3:0]  mS   [16][32];
  logic [31:0] mMru [16];
  int          mLast = 3;

  typedef struct { int core; int hit; int kept; int way; int due; string req; } exp_t;
  exp_t expQ[$];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void mTouch(int s, int w);
    logic [31:0] t;
    t = mMru[s] | (32'd1 << w);
    if (&t) t = 32'd1 << w;
    mMru[s] = t;
  endfunction

  function automatic exp_t mApply(int c, logic [1:0] k, logic [15:0] a);
    exp_t e;
    int s, hw, w;
    bit full;
    s = int'(a[3:0]);
    hw = -1;
    full = 1;
    for (int i = 0; i < 32; i++) begin
      if (mV[s][i] && mT[s][i] == a[15:4]) hw = i;
      if (!mV[s][i]) full = 0;
    end
    e.core = c; e.due = cyc + 2;
    if (k == 2'd0) begin
      if (hw >= 0) begin
        mS[s][hw] |= 4'(1 << c); mTouch(s, hw);
        e.hit = 1; e.kept = 1; e.way = hw; e.req = "R5";
      end else begin
        w = -1;
        for (int i = 31; i >= 0; i--) if (!mV[s][i]) w = i;
        if (w < 0) for (int i = 31; i >= 0; i--) if (!mMru[s][i]) w = i;
        mV[s][w] = 1; mT[s][w] = a[15:4]; mS[s][w] = 4'(1 << c); mTouch(s, w);
        e.hit = 0; e.kept = 1; e.way = w; e.req = full ? "R9" : "R4";
      end
    end else if (hw < 0) begin
      e.hit = 0; e.kept = 0; e.way = 0; e.req = (k == 2'd3) ? "R10" : "R8";
    end else begin
      e.hit = 1; e.way = hw;
      if (k == 2'd1 || $countones(mS[s][hw]) >= 2) begin
        mS[s][hw] |= 4'(1 << c); mTouch(s, hw); e.kept = 1;
      end else begin
        mV[s][hw] = 0; mS[s][hw] = 0; mMru[s][hw] = 1'b0; e.kept = 0;
      end
      e.req = (k == 2'd1) ? "R6" : ((k == 2'd3) ? "R10" : "R7");
    end
    return e;
  endfunction

  task automatic checkResp();
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      exp_t e;
      e = expQ.pop_front();
      chk(respValid === 1'b1, "R3", "respValid", int'(respValid), 1);
      chk(int'(respCore) == e.core, "R3", "respCore", int'(respCore), e.core);
      chk(int'(respHit) == e.hit, e.req, "respHit", int'(respHit), e.hit);
      chk(int'(respKept) == e.kept, e.req, "respKept", int'(respKept), e.kept);
      chk(int'(respWay) == e.way, e.req, "respWay", int'(respWay), e.way);
    end else if (respValid !== 1'b0) begin
      chk(0, "R3", "unexpected respValid", int'(respValid), 0);
    end
  endtask

  task automatic cycle();
    int g;
    @(negedge clk);
    cyc++;
    checkResp();
    for (int c = 0; c < 4; c++) begin
      reqValid[c] = pend[c];
      reqKind[c*2 +: 2] = pKind[c];
      reqAddr[c*16 +: 16] = pAddr[c];
    end
    #1;
    g = -1;
    for (int i = 1; i <= 4; i++) if (g < 0 && pend[(mLast + i) % 4]) g = (mLast + i) % 4;
    chk(int'(reqGrant) == ((g < 0) ? 0 : (1 << g)), "R2", "reqGrant",
        int'(reqGrant), (g < 0) ? 0 : (1 << g));
    if (g >= 0) begin
      expQ.push_back(mApply(g, pKind[g], pAddr[g]));
      pend[g] = 0;
      mLast = g;
    end
  endtask

  task automatic send(int c, logic [1:0] k, logic [15:0] a);
    pend[c] = 1; pKind[c] = k; pAddr[c] = a;
    while (pend[c]) cycle();
  endtask

  task automatic drain();
    repeat (4) cycle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int c = 0; c < 4; c++) begin pend[c] = 0; pKind[c] = 0; pAddr[c] = 0; end
    for (int s = 0; s < 16; s++) begin
      mMru[s] = '0;
      for (int w = 0; w < 32; w++) begin mV[s][w] = 0; mT[s][w] = 0; mS[s][w] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(respValid === 1'b0, "R1", "respValid in reset", int'(respValid), 0);
    chk(reqGrant === 4'd0, "R1", "reqGrant in reset", int'(reqGrant), 0);
    rstN = 1'b1;
    cycle();
    chk(respValid === 1'b0, "R1", "respValid after reset", int'(respValid), 0);

    // R1/R8: first fetch misses on an empty cache
    send(2, 2'd1, 16'h0A53);
    drain();
    // R4 then R7: single-owner line dropped by a data load, then fetch misses
    send(0, 2'd0, 16'h0A53);
    send(1, 2'd2, 16'h0A53);
    send(1, 2'd1, 16'h0A53);
    drain();
    // R5, R7, R6: line victimised by two cores survives a data load
    send(0, 2'd0, 16'h1236);
    send(1, 2'd0, 16'h1236);
    send(2, 2'd2, 16'h1236);
    send(3, 2'd1, 16'h1236);
    send(2, 2'd3, 16'h1236);
    drain();
    // R9: overfill set 7 so replacement follows the recently-used bits
    for (int t = 0; t < 40; t++) send(t % 4, 2'd0, {12'(t + 100), 4'd7});
    send(1, 2'd1, {12'd100, 4'd7});
    send(3, 2'd2, {12'd139, 4'd7});
    drain();
    // R2: all cores at once, twice over
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 4; c++) begin pend[c] = 1; pKind[c] = 2'd1; pAddr[c] = {12'(c), 4'd9}; end
      while (pend[0] || pend[1] || pend[2] || pend[3]) cycle();
    end
    drain();

    // Constrained random mix on a few hot sets
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < 4; c++) begin
        if (!pend[c] && ($urandom % 3 == 0)) begin
          pend[c] = 1;
          pKind[c] = 2'($urandom % 4);
          pAddr[c] = {12'($urandom % 40), 4'($urandom % 3)};
        end
      end
      cycle();
    end
    while (pend[0] || pend[1] || pend[2] || pend[3]) cycle();
    drain();
    chk(expQ.size() == 0, "R3", "responses outstanding", expQ.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule